// File: doc/BRIEF.md
# Multiplexed Register Bus Controller

This block gives a host access to a small register file over one shared 8-bit bus that carries both address and data. The host places an address on the bus while the address latch enable is high. The address is captured when that enable falls. The host then performs a read or a write with active-low chip select, read and write strobes. All strobes are asynchronous to the block's clock. Each strobe, and the bus itself, passes through a synchronizer chain of equal depth before any edge is detected. Because of this, every bus value the block samples is the one present at the synchronized strobe transition.

There are three registers: a control register, an interrupt mask and a sticky interrupt status register. Event pulses from the surrounding logic set status bits. Any status bit that is also enabled in the mask pulls the active-low interrupt output low. A read of the status register clears exactly the bits it returned, and clears them only when the read ends. An event that arrives during a read therefore survives it. The bus driver is enabled only while a read is in progress. At all other times the output is released.

Top module: `mux_regbus`

## Requirements
- R1: The register address is the bus value present when the address latch enable falls. Bus values shown earlier while the enable is high have no effect.
- R2: While chip select and the read strobe are both low, the write strobe is high and the latch enable is low, `ad_oe` is 1 and `ad_out` carries the addressed register. Otherwise `ad_oe` is 0.
- R3: A read strobe with chip select high does not enable the bus driver.
- R4: A write commits when the write strobe rises, using the bus value at that moment. The written value then reads back, and the control register also appears on `ctrl_q`.
- R5: If chip select rises before the write strobe, the write commits at that chip select edge. Bus changes made afterwards are ignored.
- R6: Chip select may be held low across several transfers without changing the results of reads or writes.
- R7: An `evt_in` pulse sets the matching status bit whatever the mask. `irq_n` goes low only when a set status bit is also set in the mask.
- R8: Reading the status register clears the bits it returned. `irq_n` returns high once no masked-in bit remains.
- R9: An event that arrives after a status read has started stays set when that read ends.
- R10: Writes to the status register are ignored.
- R11: After reset, the control register holds `CTRL_RST`, the mask and status registers read 0, `irq_n` is 1 and `ad_oe` is 0.
- R12: While the address latch enable is high, asserting read strobe and chip select does not enable the bus driver.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ale | input | 1 | Address latch enable, active high; address captured on falling edge |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| ad_in | input | DW | Shared bus, input side |
| ad_out | output | DW | Shared bus, output side (read data) |
| ad_oe | output | 1 | Bus driver enable; 0 means released |
| evt_in | input | DW | Interrupt event pulses, one per status bit |
| ctrl_q | output | DW | Current control register value |
| irq_n | output | 1 | Interrupt, active low, open-drain style |

## Verification
The bench builds the block with a three-stage synchronizer instead of the default two. It also moves the registers to addresses 0x10, 0x11 and 0x12 and uses a control reset value of 0xA5. The deeper chain lets the bench confirm that bus sampling stays aligned with the strobes when the latency changes. Relocating the registers rules out any dependence on the default map. The non-zero reset value makes the reset check meaningful. Each strobe step is held for eight clocks, which covers the chain, the edge detect and the registered interrupt output.

// File: rtl/mrb_pkg.sv
package mrb_pkg;
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_CTRL = 2'd1,
      SEL_MASK = 2'd2,
      SEL_STAT = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic rd_start;
      logic rd_end;
      logic wr_commit;
   } bus_ev_t;
endpackage

// File: rtl/mrb_sync.sv
module mrb_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/mrb_strobe_ctrl.sv
module mrb_strobe_ctrl
   import mrb_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          s_ale,
   input  logic          s_cs,
   input  logic          s_rd,
   input  logic          s_wr,
   input  logic [DW-1:0] s_bus,
   output logic [DW-1:0] addr,
   output logic          rd_act,
   output bus_ev_t       ev,
   output logic [DW-1:0] wdata
);
   logic ale_q, rd_q, wr_q;
   logic wr_act;

   assign rd_act = s_rd & s_cs & ~s_wr & ~s_ale;
   assign wr_act = s_wr & s_cs & ~s_rd & ~s_ale;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ale_q <= 1'b0;
         rd_q  <= 1'b0;
         wr_q  <= 1'b0;
         addr  <= '0;
      end else begin
         ale_q <= s_ale;
         rd_q  <= rd_act;
         wr_q  <= wr_act;
         if (ale_q && !s_ale) addr <= s_bus;
      end
   end

   assign ev.rd_start  = rd_act & ~rd_q;
   assign ev.rd_end    = ~rd_act & rd_q;
   assign ev.wr_commit = ~wr_act & wr_q;
   assign wdata        = s_bus;

   AST_NO_RD_WR_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
      ev.wr_commit |-> !rd_q); // R2
endmodule

// File: rtl/mrb_regfile.sv
module mrb_regfile
   import mrb_pkg::*;
#(
   parameter int          DW        = 8,
   parameter logic [DW-1:0] CTRL_ADDR = 8'h01,
   parameter logic [DW-1:0] MASK_ADDR = 8'h02,
   parameter logic [DW-1:0] STAT_ADDR = 8'h03,
   parameter logic [DW-1:0] CTRL_RST  = 8'h80,
   parameter bit          IRQ_REG   = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] addr,
   input  bus_ev_t       ev,
   input  logic [DW-1:0] wdata,
   input  logic [DW-1:0] evt_in,
   output logic [DW-1:0] ctrl,
   output logic [DW-1:0] rdata,
   output logic          irq
);
   reg_sel_e      sel;
   logic [DW-1:0] mask, stat, cur_val;
   logic          clr_stb;

   always_comb begin
      if      (addr == CTRL_ADDR) sel = SEL_CTRL;
      else if (addr == MASK_ADDR) sel = SEL_MASK;
      else if (addr == STAT_ADDR) sel = SEL_STAT;
      else                        sel = SEL_NONE;
   end

   always_comb begin
      unique case (sel)
         SEL_CTRL: cur_val = ctrl;
         SEL_MASK: cur_val = mask;
         SEL_STAT: cur_val = stat;
         default:  cur_val = '0;
      endcase
   end

   assign clr_stb = ev.rd_end && (sel == SEL_STAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl  <= CTRL_RST;
         mask  <= '0;
         stat  <= '0;
         rdata <= '0;
      end else begin
         if (ev.rd_start) rdata <= cur_val;
         if (ev.wr_commit && sel == SEL_CTRL) ctrl <= wdata;
         if (ev.wr_commit && sel == SEL_MASK) mask <= wdata;
         if (clr_stb) stat <= (stat & ~rdata) | evt_in;
         else         stat <= stat | evt_in;
      end
   end

   generate
      if (IRQ_REG) begin : g_irq_ff
         logic irq_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_r <= 1'b0;
            else        irq_r <= |(stat & mask);
         end
         assign irq = irq_r;
      end else begin : g_irq_comb
         assign irq = |(stat & mask);
      end
   endgenerate

   AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (|($past(stat) & ~stat)) |-> $past(clr_stb)); // R8
   AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt_in) |=> ((stat & $past(evt_in)) == $past(evt_in))); // R7
   AST_STAT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (ev.wr_commit && sel == SEL_STAT) |=> (stat == ($past(stat) | $past(evt_in)))); // R10
   AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(ev.wr_commit && sel == SEL_CTRL) |=> $stable(ctrl)); // R4
endmodule

// File: rtl/mux_regbus.sv
module mux_regbus
   import mrb_pkg::*;
#(
   parameter int            DW          = 8,
   parameter int            SYNC_STAGES = 2,
   parameter logic [DW-1:0] CTRL_ADDR   = 8'h01,
   parameter logic [DW-1:0] MASK_ADDR   = 8'h02,
   parameter logic [DW-1:0] STAT_ADDR   = 8'h03,
   parameter logic [DW-1:0] CTRL_RST    = 8'h80,
   parameter bit            IRQ_REG     = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ale,
   input  logic          cs_n,
   input  logic          rd_n,
   input  logic          wr_n,
   input  logic [DW-1:0] ad_in,
   output logic [DW-1:0] ad_out,
   output logic          ad_oe,
   input  logic [DW-1:0] evt_in,
   output logic [DW-1:0] ctrl_q,
   output logic          irq_n
);
   localparam int NSTB = 4;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (CTRL_ADDR == MASK_ADDR || CTRL_ADDR == STAT_ADDR || MASK_ADDR == STAT_ADDR) begin : g_bad_map
         $error("register addresses must be distinct");
      end
      if (DW < 1) begin : g_bad_dw
         $error("DW must be positive");
      end
   endgenerate

   logic [NSTB-1:0] stb_raw, stb_s;
   logic [DW-1:0]   bus_s, addr, wdata, rdata;
   logic            s_ale, s_cs, s_rd, s_wr, rd_act, oe_q, irq;
   bus_ev_t         ev;

   assign stb_raw = {ale, ~cs_n, ~rd_n, ~wr_n};
   assign {s_ale, s_cs, s_rd, s_wr} = stb_s;

   mrb_sync #(.W(NSTB), .STAGES(SYNC_STAGES)) u_sync_stb (
      .clk(clk), .rst_n(rst_n), .d(stb_raw), .q(stb_s));

   mrb_sync #(.W(DW), .STAGES(SYNC_STAGES)) u_sync_bus (
      .clk(clk), .rst_n(rst_n), .d(ad_in), .q(bus_s));

   mrb_strobe_ctrl #(.DW(DW)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .s_ale(s_ale), .s_cs(s_cs), .s_rd(s_rd), .s_wr(s_wr), .s_bus(bus_s),
      .addr(addr), .rd_act(rd_act), .ev(ev), .wdata(wdata));

   mrb_regfile #(
      .DW(DW), .CTRL_ADDR(CTRL_ADDR), .MASK_ADDR(MASK_ADDR),
      .STAT_ADDR(STAT_ADDR), .CTRL_RST(CTRL_RST), .IRQ_REG(IRQ_REG)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(addr), .ev(ev), .wdata(wdata),
      .evt_in(evt_in), .ctrl(ctrl_q), .rdata(rdata), .irq(irq));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) oe_q <= 1'b0;
      else        oe_q <= rd_act;
   end

   assign ad_oe  = oe_q;
   assign ad_out = rdata;
   assign irq_n  = ~irq;

   AST_OE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
      ad_oe |-> $past(s_cs && !s_ale)); // R3
   AST_OE_NEEDS_RD: assert property (@(posedge clk) disable iff (!rst_n)
      ad_oe |-> $past(s_rd && !s_wr)); // R2
endmodule

// File: tb/mux_regbus_test.sv
module mux_regbus_test;
   localparam int          PERIOD = 10;
   localparam int          WT     = 8;
   localparam logic [7:0]  CA = 8'h10, MA = 8'h11, SA = 8'h12, CR = 8'hA5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ale = 1'b0, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
   logic [7:0] ad_in = '0, evt_in = '0;
   logic [7:0] ad_out, ctrl_q;
   logic       ad_oe, irq_n;
   int         total = 0, bad = 0;
   bit         perm = 1'b0;

   always #(PERIOD/2) clk = ~clk;

   mux_regbus #(
      .DW(8), .SYNC_STAGES(3), .CTRL_ADDR(CA), .MASK_ADDR(MA),
      .STAT_ADDR(SA), .CTRL_RST(CR), .IRQ_REG(1'b1)
   ) uut (
      .clk(clk), .rst_n(rst_n), .ale(ale), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
      .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .evt_in(evt_in),
      .ctrl_q(ctrl_q), .irq_n(irq_n));

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wt();
      repeat (WT) @(negedge clk);
   endtask

   task automatic latch(input logic [7:0] a);
      ale = 1'b1; ad_in = a; wt();
      ale = 1'b0; wt();
   endtask

   task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
      latch(a);
      ad_in = d; cs_n = 1'b0; wr_n = 1'b0; wt();
      wr_n = 1'b1; wt();
      if (!perm) cs_n = 1'b1;
      wt();
   endtask

   task automatic rd_reg(input logic [7:0] a, output logic [7:0] d, output logic oe);
      latch(a);
      cs_n = 1'b0; rd_n = 1'b0; wt();
      d = ad_out; oe = ad_oe;
      rd_n = 1'b1; wt();
      if (!perm) cs_n = 1'b1;
      wt();
   endtask

   task automatic pulse(input logic [7:0] v);
      evt_in = v; @(negedge clk);
      evt_in = '0;
   endtask

   task automatic t_reset();
      logic [7:0] d; logic oe;
      chk("R11 ctrl", ctrl_q, CR);
      chk("R11 irq_n", {7'b0, irq_n}, 8'h01);
      chk("R11 oe", {7'b0, ad_oe}, 8'h00);
      rd_reg(MA, d, oe); chk("R11 mask", d, 8'h00);
      rd_reg(SA, d, oe); chk("R11 stat", d, 8'h00);
   endtask

   task automatic t_rw();
      logic [7:0] d; logic oe;
      wr_reg(CA, 8'h3C);
      chk("R4 ctrl_q", ctrl_q, 8'h3C);
      rd_reg(CA, d, oe);
      chk("R4 readback", d, 8'h3C);
      chk("R2 oe in read", {7'b0, oe}, 8'h01);
      chk("R2 oe idle", {7'b0, ad_oe}, 8'h00);
      wr_reg(MA, 8'h81);
      rd_reg(MA, d, oe);
      chk("R2 mask read", d, 8'h81);
   endtask

   task automatic t_addr_latch();
      logic [7:0] d, oe_l;
      ale = 1'b1; ad_in = MA; wt();
      ad_in = SA; wt();
      ad_in = CA; wt();
      ale = 1'b0; wt();
      ad_in = 8'hEE;
      cs_n = 1'b0; rd_n = 1'b0; wt();
      d = ad_out; oe_l = {7'b0, ad_oe};
      rd_n = 1'b1; wt(); cs_n = 1'b1; wt();
      chk("R1 last addr wins", d, 8'h3C);
      chk("R1 oe", oe_l, 8'h01);
   endtask

   task automatic t_cs_gate();
      latch(CA);
      rd_n = 1'b0; wt();
      chk("R3 no cs no drive", {7'b0, ad_oe}, 8'h00);
      rd_n = 1'b1; wt();
      ale = 1'b1; ad_in = CA; wt();
      cs_n = 1'b0; rd_n = 1'b0; wt();
      chk("R12 ale high no drive", {7'b0, ad_oe}, 8'h00);
      ale = 1'b0; wt();
      rd_n = 1'b1; wt(); cs_n = 1'b1; wt();
      chk("R12 ctrl kept", ctrl_q, 8'h3C);
   endtask

   task automatic t_cs_first();
      logic [7:0] d; logic oe;
      latch(CA);
      ad_in = 8'h5A; cs_n = 1'b0; wr_n = 1'b0; wt();
      cs_n = 1'b1; wt();
      ad_in = 8'hFF; wt();
      wr_n = 1'b1; wt();
      chk("R5 commit at cs", ctrl_q, 8'h5A);
      rd_reg(CA, d, oe);
      chk("R5 readback", d, 8'h5A);
   endtask

   task automatic t_perm_cs();
      logic [7:0] d; logic oe;
      perm = 1'b1; cs_n = 1'b0; wt();
      wr_reg(CA, 8'hC3);
      rd_reg(CA, d, oe);
      chk("R6 readback", d, 8'hC3);
      wr_reg(MA, 8'h01);
      rd_reg(MA, d, oe);
      chk("R6 mask", d, 8'h01);
      chk("R6 ctrl_q", ctrl_q, 8'hC3);
      perm = 1'b0; cs_n = 1'b1; wt();
   endtask

   task automatic t_irq();
      logic [7:0] d; logic oe;
      pulse(8'h02); wt();
      chk("R7 masked off no irq", {7'b0, irq_n}, 8'h01);
      rd_reg(SA, d, oe);
      chk("R7 status records", d, 8'h02);
      pulse(8'h01); wt();
      chk("R7 irq low", {7'b0, irq_n}, 8'h00);
      rd_reg(SA, d, oe);
      chk("R8 status read", d, 8'h01);
      chk("R8 irq released", {7'b0, irq_n}, 8'h01);
      rd_reg(SA, d, oe);
      chk("R8 cleared", d, 8'h00);
   endtask

   task automatic t_evt_during_read();
      logic [7:0] d1, d2; logic oe;
      pulse(8'h04); wt();
      latch(SA);
      cs_n = 1'b0; rd_n = 1'b0; wt();
      d1 = ad_out;
      pulse(8'h08); wt();
      rd_n = 1'b1; wt(); cs_n = 1'b1; wt();
      chk("R9 first read", d1, 8'h04);
      rd_reg(SA, d2, oe);
      chk("R9 late event kept", d2, 8'h08);
   endtask

   task automatic t_stat_ro();
      logic [7:0] d; logic oe;
      wr_reg(SA, 8'hFF);
      rd_reg(SA, d, oe);
      chk("R10 stat write ignored", d, 8'h00);
      chk("R10 irq_n", {7'b0, irq_n}, 8'h01);
   endtask

   bit done = 1'b0;

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      wt();
      t_reset();
      t_rw();
      t_addr_latch();
      t_cs_gate();
      t_cs_first();
      t_perm_cs();
      t_irq();
      t_evt_during_read();
      t_stat_ro();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++; bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule